// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a lower-level memory port. Each 40-bit physical address is cut into three parts: a tag, a set index and a 6-bit line offset. Both ways of the indexed set are looked up at the same time. On a hit, the 64-bit word is returned in the same cycle the request is presented. Stores that hit merge their enabled bytes into the cached word, mark the line dirty and send nothing to memory.

On a miss, a victim way is picked. An empty way is taken first. When both ways are valid, the least recently used way is taken, tracked by one bit per set. A dirty victim is written back as a whole 64-byte line. The missing line is then fetched. After the fill, the original access is replayed as a hit, so a store miss allocates the line and then merges into it. The processor waits with ready low for the whole sequence.

The memory side moves whole lines. A request stays asserted and unchanged until the memory accepts it. Read data comes back later on a separate valid strobe.

Top module: `cache2w_wb_top`

## Requirements
- R1: The set index is address bits [6 +: log2(SETS)] and the tag is the remaining upper bits. Bits [5:3] select one of eight 64-bit words in the line, and bits [2:0] have no effect on which word is accessed.
- R2: A read that hits raises cpu_ready in the same cycle as the request, with the addressed word on cpu_rdata, and causes no memory transfer.
- R3: Two lines with different tags and the same index are held at once, one per way, and both hit afterwards.
- R4: A miss in a set whose two ways are valid replaces the way used least recently. Both hits and fills count as a use.
- R5: A store hit changes only the cached word, marks the line dirty and issues no memory write.
- R6: Evicting a dirty line writes the full line, including earlier stores, to its own line address (tag, index, six zero bits) before the fetch. Evicting a clean line issues no write.
- R7: A store miss fetches the line from memory and then merges the store into it. Later reads return the merged word.
- R8: On a store, only bytes whose cpu_be bit is set change. Bit b covers bits [8b+7:8b] of the word.
- R9: After reset no line is valid: cpu_ready and mem_valid are low while idle, and the first access misses.
- R10: If a way of the indexed set is invalid, the miss fills it without evicting the valid way.
- R11: A memory request holds mem_valid, mem_write and mem_addr steady until mem_ready. cpu_ready stays low until the miss sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 40 | Physical byte address |
| cpu_wdata | input | 64 | Store data |
| cpu_be | input | 8 | Store byte enables |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 64 | Load data, valid with cpu_ready |
| mem_valid | output | 1 | Line request to memory |
| mem_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 40 | Line-aligned address |
| mem_wdata | output | 512 | Write-back line |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Fetched line is present |
| mem_rdata | input | 512 | Fetched line |

## Verification
A wrong LRU bit, valid bit or dirty bit has no immediate effect at the ports. It shows up only on the next miss to that set: a write-back that should or should not happen, a write-back to the wrong address, or a later re-fetch of a line that should still be resident. The directed sequences therefore force an eviction right after each state change, and count memory reads and writes across it. A store merged into the wrong bytes or word first shows up in the data of the line evicted from the cache. It shows up again when that line is read back after a re-fetch, so the bench checks both.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int ADDR_W     = 40;
    localparam int WORD_W     = 64;
    localparam int BE_W       = WORD_W / 8;
    localparam int LINE_BYTES = 64;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BYTE_OFF_W = $clog2(BE_W);
    localparam int WSEL_W     = OFF_W - BYTE_OFF_W;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_EVICT = 2'd1,
        CS_FETCH = 2'd2,
        CS_WAIT  = 2'd3
    } cstate_e;

    function automatic word_t pick_word(line_t l, logic [WSEL_W-1:0] s);
        return l[int'(s)*WORD_W +: WORD_W];
    endfunction

    function automatic line_t merge_word(line_t l, logic [WSEL_W-1:0] s,
                                         word_t d, logic [BE_W-1:0] be);
        line_t r;
        r = l;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[int'(s)*WORD_W + b*8 +: 8] = d[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      idx,
    output logic [1:0]            way_valid,
    output logic [1:0]            way_dirty,
    output logic [1:0][TAG_W-1:0] way_tag,
    output logic                  lru_way,
    input  logic                  touch_en,
    input  logic                  touch_way,
    input  logic                  fill_en,
    input  logic                  fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  dirty_en,
    input  logic                  dirty_way
);
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[idx] <= ~touch_way;
        end
    end
    assign lru_way = lru_q[idx];

    for (genvar g = 0; g < 2; g++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (fill_en && fill_way == 1'(g)) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end else if (dirty_en && dirty_way == 1'(g)) begin
                dirty_q[idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(g)) tag_q[idx] <= fill_tag;
        end

        assign way_valid[g] = valid_q[idx];
        assign way_dirty[g] = dirty_q[idx];
        assign way_tag[g]   = tag_q[idx];

        assert_dirty_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
            (dirty_q & ~valid_q) == '0);

        assert_fill_leaves_clean_R6: assert property (@(posedge clk) disable iff (rst)
            (fill_en && fill_way == 1'(g)) |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));
    end
endmodule

// File: rtl/cache2w_lines.sv
module cache2w_lines
    import cache2w_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       idx,
    output line_t [1:0]            way_line,
    input  logic                   fill_en,
    input  logic                   fill_way,
    input  line_t                  fill_line,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [WSEL_W-1:0]      wr_sel,
    input  word_t                  wr_data,
    input  logic [BE_W-1:0]        wr_be
);
    for (genvar g = 0; g < 2; g++) begin : g_way
        line_t store_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(g)) begin
                store_q[idx] <= fill_line;
            end else if (wr_en && wr_way == 1'(g)) begin
                store_q[idx] <= merge_word(store_q[idx], wr_sel, wr_data, wr_be);
            end
        end

        assign way_line[g] = store_q[idx];
    end
endmodule

// File: rtl/cache2w_seq.sv
module cache2w_seq
    import cache2w_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    miss_start,
    input  logic    need_wb,
    input  logic    mem_ready,
    input  logic    mem_rvalid,
    output cstate_e state
);
    cstate_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            CS_IDLE:  if (miss_start) state_d = need_wb ? CS_EVICT : CS_FETCH;
            CS_EVICT: if (mem_ready)  state_d = CS_FETCH;
            CS_FETCH: if (mem_ready)  state_d = CS_WAIT;
            CS_WAIT:  if (mem_rvalid) state_d = CS_IDLE;
            default:  state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CS_IDLE;
        else     state <= state_d;
    end

    assert_wait_after_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        (state == CS_WAIT) |-> ($past(state) == CS_FETCH || $past(state) == CS_WAIT));
endmodule

// File: rtl/cache2w_wb_top.sv
module cache2w_wb_top
    import cache2w_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_wsel;
    logic [BYTE_OFF_W-1:0] unused_byte_off;

    assign req_idx         = cpu_addr[OFF_W +: IDX_W];
    assign req_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_wsel        = cpu_addr[BYTE_OFF_W +: WSEL_W];
    assign unused_byte_off = cpu_addr[BYTE_OFF_W-1:0];

    logic [1:0]            way_valid, way_dirty;
    logic [1:0][TAG_W-1:0] way_tag;
    line_t [1:0]           way_line;
    logic                  lru_way;
    cstate_e               state;

    logic [1:0] hit_vec;
    logic       hit, hit_way;
    logic       vic_comb, vic_q, need_wb, miss_start;
    logic       fill_en, touch_en, touch_way, store_en;

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == req_tag);
    end
    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    always_comb begin
        if (!way_valid[0])      vic_comb = 1'b0;
        else if (!way_valid[1]) vic_comb = 1'b1;
        else                    vic_comb = lru_way;
    end

    assign need_wb    = way_valid[vic_comb] && way_dirty[vic_comb];
    assign miss_start = (state == CS_IDLE) && cpu_req && !hit;

    always_ff @(posedge clk) begin
        if (rst)             vic_q <= 1'b0;
        else if (miss_start) vic_q <= vic_comb;
    end

    assign cpu_ready = (state == CS_IDLE) && cpu_req && hit;
    assign cpu_rdata = pick_word(way_line[hit_way], req_wsel);
    assign store_en  = cpu_ready && cpu_we;
    assign fill_en   = (state == CS_WAIT) && mem_rvalid;
    assign touch_en  = cpu_ready || fill_en;
    assign touch_way = fill_en ? vic_q : hit_way;

    assign mem_valid = (state == CS_EVICT) || (state == CS_FETCH);
    assign mem_write = (state == CS_EVICT);
    assign mem_addr  = (state == CS_EVICT) ? {way_tag[vic_q], req_idx, {OFF_W{1'b0}}}
                                           : {req_tag, req_idx, {OFF_W{1'b0}}};
    assign mem_wdata = way_line[vic_q];

    cache2w_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .miss_start (miss_start),
        .need_wb    (need_wb),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .state      (state)
    );

    cache2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
        .clk       (clk),
        .rst       (rst),
        .idx       (req_idx),
        .way_valid (way_valid),
        .way_dirty (way_dirty),
        .way_tag   (way_tag),
        .lru_way   (lru_way),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .fill_en   (fill_en),
        .fill_way  (vic_q),
        .fill_tag  (req_tag),
        .dirty_en  (store_en),
        .dirty_way (hit_way)
    );

    cache2w_lines #(.SETS(SETS)) i_lines (
        .clk       (clk),
        .idx       (req_idx),
        .way_line  (way_line),
        .fill_en   (fill_en),
        .fill_way  (vic_q),
        .fill_line (mem_rdata),
        .wr_en     (store_en),
        .wr_way    (hit_way),
        .wr_sel    (req_wsel),
        .wr_data   (cpu_wdata),
        .wr_be     (cpu_be)
    );

    assert_single_way_hit_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (way_valid[vic_q] && way_dirty[vic_q]));

    assert_fill_only_on_miss_R7: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !hit);

    assert_mem_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
endmodule

// File: tb/test_cache2w_wb_top.sv
module test_cache2w_wb_top;
    import cache2w_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [WORD_W-1:0] cpu_wdata = '0;
    logic [BE_W-1:0]   cpu_be = '0;
    logic              cpu_ready;
    logic [WORD_W-1:0] cpu_rdata;
    logic              mem_valid, mem_write;
    logic [ADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ready = 1'b0;
    logic              mem_rvalid = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    cache2w_wb_top #(.SETS(4)) i_cache2w_wb_top (.*);

    always #(CLK_P/2) clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // memory model
    line_t mem_lines [logic [ADDR_W-1:0]];
    word_t shadow [logic [ADDR_W-1:0]];
    int rd_count = 0, wb_count = 0, rd_timer = 0;
    bit seen = 0;
    logic [ADDR_W-1:0] rd_addr, last_wb_addr;
    line_t last_wb_line;

    function automatic word_t pat(logic [ADDR_W-1:0] a, int w);
        return {a[39:8], 6'b0, a[7:6], 16'hBEEF, 13'b0, 3'(w)};
    endfunction

    function automatic line_t mem_line(logic [ADDR_W-1:0] a);
        line_t l;
        if (mem_lines.exists(a)) return mem_lines[a];
        for (int w = 0; w < 8; w++) l[w*64 +: 64] = pat(a, w);
        return l;
    endfunction

    function automatic word_t exp_word(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] k;
        k = {a[39:3], 3'b0};
        if (shadow.exists(k)) return shadow[k];
        return pat({a[39:6], 6'b0}, int'(a[5:3]));
    endfunction

    function automatic logic [ADDR_W-1:0] mk(logic [31:0] tag, logic [1:0] idx, logic [2:0] w);
        return {tag, idx, w, 3'b0};
    endfunction

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rd_timer > 0) begin
            rd_timer--;
            if (rd_timer == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_line(rd_addr);
            end
        end
        if (mem_ready) begin
            mem_ready = 1'b0;
            seen = 0;
        end else if (mem_valid) begin
            if (seen) begin
                mem_ready = 1'b1;
                if (mem_write) begin
                    mem_lines[mem_addr] = mem_wdata;
                    wb_count++;
                    last_wb_addr = mem_addr;
                    last_wb_line = mem_wdata;
                end else begin
                    rd_count++;
                    rd_addr  = mem_addr;
                    rd_timer = 2;
                end
            end else begin
                seen = 1;
            end
        end
    end

    task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [ADDR_W-1:0] a, input word_t d,
                          input logic [7:0] be, output word_t rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 1000) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) begin
            word_t o;
            o = exp_word(a);
            for (int b = 0; b < 8; b++) if (be[b]) o[b*8 +: 8] = d[b*8 +: 8];
            shadow[{a[39:3], 3'b0}] = o;
        end
    endtask

    localparam logic [31:0] TA = 32'h0000_1111, TB = 32'h0000_2222,
                            TC = 32'h0000_3333, TD = 32'h0000_4444,
                            TE = 32'h0000_5555, TF = 32'h0000_6666,
                            TG = 32'h0000_7777, TH = 32'h0000_8888;

    task automatic t_reset();
        word_t r; int w, rc;
        check(cpu_ready == 1'b0, "R9 ready low idle", 512'(cpu_ready), 0);
        check(mem_valid == 1'b0, "R9 mem idle", 512'(mem_valid), 0);
        rc = rd_count;
        access(0, mk(TA, 0, 1), '0, '0, r, w);
        check(w > 0 && rd_count == rc + 1, "R9 first access misses", 512'(rd_count - rc), 1);
        check(r == exp_word(mk(TA, 0, 1)), "R11 data after miss", 512'(r), 512'(exp_word(mk(TA, 0, 1))));
    endtask

    task automatic t_read_hit();
        word_t r; int w, rc;
        rc = rd_count;
        access(0, mk(TA, 0, 6), '0, '0, r, w);
        check(w == 0 && rd_count == rc, "R2 hit no wait", 512'(w), 0);
        check(r == exp_word(mk(TA, 0, 6)), "R2 hit data", 512'(r), 512'(exp_word(mk(TA, 0, 6))));
        access(0, mk(TA, 0, 6) | 40'h5, '0, '0, r, w);
        check(r == exp_word(mk(TA, 0, 6)), "R1 byte offset ignored", 512'(r), 512'(exp_word(mk(TA, 0, 6))));
    endtask

    task automatic t_two_ways();
        word_t r; int w, rc, wc;
        rc = rd_count; wc = wb_count;
        access(0, mk(TB, 0, 0), '0, '0, r, w);
        check(rd_count == rc + 1 && wb_count == wc, "R10 empty way filled", 512'(rd_count - rc), 1);
        access(0, mk(TA, 0, 2), '0, '0, r, w);
        check(w == 0, "R10 way A kept", 512'(w), 0);
        access(0, mk(TB, 0, 3), '0, '0, r, w);
        check(w == 0 && r == exp_word(mk(TB, 0, 3)), "R3 both ways hit", 512'(w), 0);
    endtask

    task automatic t_lru();
        word_t r; int w, rc;
        access(0, mk(TA, 0, 0), '0, '0, r, w);   // A most recent, B is LRU
        rc = rd_count;
        access(0, mk(TC, 0, 0), '0, '0, r, w);   // evicts B
        check(rd_count == rc + 1, "R4 miss on third tag", 512'(rd_count - rc), 1);
        access(0, mk(TA, 0, 4), '0, '0, r, w);
        check(w == 0, "R4 recent way kept", 512'(w), 0);
        rc = rd_count;
        access(0, mk(TB, 0, 4), '0, '0, r, w);   // evicts C (A just used)
        check(w > 0 && rd_count == rc + 1, "R4 LRU way was evicted", 512'(w), 1);
        access(0, mk(TA, 0, 5), '0, '0, r, w);
        check(w == 0, "R4 A survives second miss", 512'(w), 0);
    endtask

    task automatic t_store_hit();
        word_t r; int w, wc;
        wc = wb_count;
        access(1, mk(TA, 0, 2), 64'h1122_3344_5566_7788, 8'h0F, r, w);
        check(w == 0 && wb_count == wc, "R5 store hit no write", 512'(wb_count - wc), 0);
        access(0, mk(TA, 0, 2), '0, '0, r, w);
        check(r == {pat(mk(TA, 0, 0), 2)[63:32], 32'h5566_7788}, "R8 low bytes only",
              512'(r), 512'({pat(mk(TA, 0, 0), 2)[63:32], 32'h5566_7788}));
        access(0, mk(TA, 0, 3), '0, '0, r, w);
        check(r == exp_word(mk(TA, 0, 3)), "R5 other word unchanged", 512'(r), 512'(exp_word(mk(TA, 0, 3))));
    endtask

    task automatic t_dirty_evict();
        word_t r; int w, wc, rc;
        line_t exp_l;
        access(0, mk(TB, 0, 0), '0, '0, r, w);   // A becomes LRU, A dirty
        wc = wb_count;
        access(0, mk(TD, 0, 0), '0, '0, r, w);
        check(wb_count == wc + 1, "R6 dirty victim written", 512'(wb_count - wc), 1);
        check(last_wb_addr == mk(TA, 0, 0), "R6 write-back address", 512'(last_wb_addr), 512'(mk(TA, 0, 0)));
        exp_l = mem_line(40'h0);
        for (int k = 0; k < 8; k++) exp_l[k*64 +: 64] = exp_word(mk(TA, 0, 3'(k)));
        check(last_wb_line == exp_l, "R6 write-back line", last_wb_line, exp_l);
        rc = rd_count;
        access(0, mk(TA, 0, 2), '0, '0, r, w);
        check(rd_count == rc + 1 && r == exp_word(mk(TA, 0, 2)), "R6 evicted store kept",
              512'(r), 512'(exp_word(mk(TA, 0, 2))));
    endtask

    task automatic t_store_miss();
        word_t r; int w, wc, rc;
        wc = wb_count; rc = rd_count;
        access(1, mk(TE, 1, 5), 64'hDEAD_BEEF_0000_0000, 8'hF0, r, w);
        check(w > 0 && rd_count == rc + 1 && wb_count == wc, "R7 store miss allocates",
              512'(rd_count - rc), 1);
        access(0, mk(TE, 1, 5), '0, '0, r, w);
        check(w == 0 && r == {32'hDEAD_BEEF, pat(mk(TE, 1, 0), 5)[31:0]}, "R7 R8 merged word",
              512'(r), 512'({32'hDEAD_BEEF, pat(mk(TE, 1, 0), 5)[31:0]}));
        access(0, mk(TE, 1, 4), '0, '0, r, w);
        check(r == exp_word(mk(TE, 1, 4)), "R7 neighbour word", 512'(r), 512'(exp_word(mk(TE, 1, 4))));
    endtask

    task automatic t_clean_evict();
        word_t r; int w, wc;
        access(0, mk(TF, 2, 0), '0, '0, r, w);
        access(0, mk(TG, 2, 0), '0, '0, r, w);
        wc = wb_count;
        access(0, mk(TH, 2, 7), '0, '0, r, w);
        check(wb_count == wc && r == exp_word(mk(TH, 2, 7)), "R6 clean eviction no write",
              512'(wb_count - wc), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_hit();
        t_two_ways();
        t_lru();
        t_store_hit();
        t_dirty_evict();
        t_store_miss();
        t_clean_evict();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            vectors++; misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule